// File: doc/BRIEF.md
# Single-Level Address Translation Unit with Access and Modify Tracking

This block translates a virtual address into a physical address by looking up a small page table that it holds in registers. Each request carries a virtual address and a flag that says whether it is a load or a store. The upper bits of the address select a table entry. The lower bits form the page offset and pass through unchanged. One cycle after the request, the block returns one of two results: a physical address, or a fault flag with a cause code and the page number that faulted. Software uses the fault to decide what to do next.

Each table entry holds five fields: a frame number, a read permission, a write permission, a modified flag and an accessed flag. The block does not store a separate presence bit. A page with both permissions cleared counts as absent. Software loads whole entries through a write port and reads any entry back through a combinational readback port.

The translation logic updates the two tracking flags as a side effect. Every successful access sets the accessed flag, and every successful store also sets the modified flag. Software can clear both flags by rewriting the entry. It can also clear the write permission of a page to get a fault on the first store, which lets it track modified pages itself.

Top module: `page_xlate_unit`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R2: A successful access returns `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = {entry frame number, address bits [OFF_W-1:0] unchanged}.
- R3: A page number (address bits [VA_W-1:OFF_W]) of NUM_PAGES (48) or more faults with cause 1. This check takes priority over all others.
- R4: A page in range whose read and write permissions are both 0 is absent and faults with cause 2.
- R5: A load to a page without read permission, or a store to a page without write permission, faults with cause 3. For example, a store to a read-only page faults.
- R6: On a fault, `rsp_fault`=1, `rsp_fault_vpn` holds the requested page number and `rsp_paddr` is 0. On success, `rsp_fault_vpn` is 0.
- R7: Every successful access sets the accessed flag of its entry. The new value is visible on readback after the response edge.
- R8: A successful store also sets the entry's modified flag. A successful load leaves the modified flag unchanged.
- R9: A faulting access leaves the accessed and modified flags of every entry unchanged.
- R10: A software write loads all five fields of the selected entry, which is how software clears the tracking flags. A write to an index of 48 or more is ignored, and readback of such an index returns zeros. Reset clears every entry.
- R11: When software writes an entry in the same cycle that an access hits it, the software value wins for the tracking flags. The access is still translated with the contents the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | VA_W (16) | Virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 0 ok, 1 page out of range, 2 absent, 3 permission |
| rsp_fault_vpn | output | VPN_W (6) | Page number of the faulting request |
| rsp_paddr | output | PFN_W+OFF_W (18) | Physical address on success |
| sw_wr_en | input | 1 | Software entry write strobe |
| sw_idx | input | VPN_W (6) | Entry index for the write and for readback |
| sw_pfn | input | PFN_W (8) | Frame number to load |
| sw_perm_rd | input | 1 | Read permission to load |
| sw_perm_wr | input | 1 | Write permission to load |
| sw_ref | input | 1 | Accessed flag to load |
| sw_dirty | input | 1 | Modified flag to load |
| rb_pfn | output | PFN_W (8) | Readback frame number of entry `sw_idx` |
| rb_perm_rd | output | 1 | Readback read permission |
| rb_perm_wr | output | 1 | Readback write permission |
| rb_ref | output | 1 | Readback accessed flag |
| rb_dirty | output | 1 | Readback modified flag |

## Verification
A request driven before a rising edge produces its response and its flag updates on that same edge. The bench drives each request after a falling edge, waits for the next falling edge, and checks every response field there. At that falling edge it also samples the combinational readback of the entry, which already shows the new flags. Software writes take effect on the same edge, and their readback is sampled half a cycle later. The collision test puts a software write and an access to one entry on a single edge, then checks the response against the old entry contents and the flags against the software value.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_RANGE  = 2'd1,
    CAUSE_ABSENT = 2'd2,
    CAUSE_PERM   = 2'd3
  } pxu_cause_e;

  // Priority: range, then presence, then permission for the access kind.
  function automatic pxu_cause_e pxu_classify(input logic in_range,
                                              input logic perm_rd,
                                              input logic perm_wr,
                                              input logic is_write);
    if (!in_range)
      return CAUSE_RANGE;
    else if (!perm_rd && !perm_wr)
      return CAUSE_ABSENT;
    else if (is_write ? !perm_wr : !perm_rd)
      return CAUSE_PERM;
    else
      return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/pxu_entry_store.sv
module pxu_entry_store #(
  parameter int NUM_PAGES = 48,
  parameter int VPN_W     = 6,
  parameter int PFN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [VPN_W-1:0] sw_idx,
  input  logic [PFN_W-1:0] sw_pfn,
  input  logic             sw_perm_rd,
  input  logic             sw_perm_wr,
  input  logic             sw_ref,
  input  logic             sw_dirty,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_perm_rd,
  output logic             lk_perm_wr,
  input  logic             upd_ref_en,
  input  logic             upd_dirty_en,
  input  logic [VPN_W-1:0] upd_vpn,
  output logic [PFN_W-1:0] rb_pfn,
  output logic             rb_perm_rd,
  output logic             rb_perm_wr,
  output logic             rb_ref,
  output logic             rb_dirty
);

  function automatic logic idx_ok(input logic [VPN_W-1:0] v);
    return int'(v) < NUM_PAGES;
  endfunction

  logic [PFN_W-1:0]     pfn_arr [NUM_PAGES];
  logic [NUM_PAGES-1:0] prd_vec;
  logic [NUM_PAGES-1:0] pwr_vec;
  logic [NUM_PAGES-1:0] ref_vec;
  logic [NUM_PAGES-1:0] dirty_vec;

  // Named events for the assertions.
  logic sw_valid_wr;
  logic upd_collide;
  assign sw_valid_wr = sw_wr_en && idx_ok(sw_idx);
  assign upd_collide = sw_wr_en && (sw_idx == upd_vpn);

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_ent
    logic             sel_sw;
    logic             sel_upd;
    logic [PFN_W-1:0] e_pfn_q;
    logic             e_prd_q;
    logic             e_pwr_q;
    logic             e_ref_q;
    logic             e_dirty_q;

    assign sel_sw  = sw_wr_en && (sw_idx == VPN_W'(i));
    assign sel_upd = (upd_vpn == VPN_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_pfn_q   <= '0;
        e_prd_q   <= 1'b0;
        e_pwr_q   <= 1'b0;
        e_ref_q   <= 1'b0;
        e_dirty_q <= 1'b0;
      end else if (sel_sw) begin
        e_pfn_q   <= sw_pfn;
        e_prd_q   <= sw_perm_rd;
        e_pwr_q   <= sw_perm_wr;
        e_ref_q   <= sw_ref;
        e_dirty_q <= sw_dirty;
      end else if (sel_upd) begin
        if (upd_ref_en)   e_ref_q   <= 1'b1;
        if (upd_dirty_en) e_dirty_q <= 1'b1;
      end
    end

    assign pfn_arr[i]   = e_pfn_q;
    assign prd_vec[i]   = e_prd_q;
    assign pwr_vec[i]   = e_pwr_q;
    assign ref_vec[i]   = e_ref_q;
    assign dirty_vec[i] = e_dirty_q;
  end

  logic lk_in, rb_in;
  assign lk_in = idx_ok(lk_vpn);
  assign rb_in = idx_ok(sw_idx);

  always_comb begin
    lk_pfn     = '0;
    lk_perm_rd = 1'b0;
    lk_perm_wr = 1'b0;
    if (lk_in) begin
      lk_pfn     = pfn_arr[lk_vpn];
      lk_perm_rd = prd_vec[lk_vpn];
      lk_perm_wr = pwr_vec[lk_vpn];
    end
  end

  always_comb begin
    rb_pfn     = '0;
    rb_perm_rd = 1'b0;
    rb_perm_wr = 1'b0;
    rb_ref     = 1'b0;
    rb_dirty   = 1'b0;
    if (rb_in) begin
      rb_pfn     = pfn_arr[sw_idx];
      rb_perm_rd = prd_vec[sw_idx];
      rb_perm_wr = pwr_vec[sw_idx];
      rb_ref     = ref_vec[sw_idx];
      rb_dirty   = dirty_vec[sw_idx];
    end
  end

  // R7: a successful access leaves the accessed flag set unless software overrode it.
  assert_ref_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ref_en && !upd_collide) |=> ref_vec[$past(upd_vpn)]);

  // R8: a successful store leaves the modified flag set.
  assert_dirty_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dirty_en && !upd_collide) |=> dirty_vec[$past(upd_vpn)]);

  // R9: without an update or a software write the tracking flags hold.
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_ref_en && !upd_dirty_en && !sw_wr_en) |=> ($stable(ref_vec) && $stable(dirty_vec)));

  // R11: a software write decides the tracking flags of its entry.
  assert_sw_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid_wr |=> (ref_vec[$past(sw_idx)] == $past(sw_ref)) &&
                    (dirty_vec[$past(sw_idx)] == $past(sw_dirty)));

endmodule

// File: rtl/pxu_access_check.sv
module pxu_access_check
  import pxu_pkg::*;
#(
  parameter int NUM_PAGES = 48,
  parameter int VPN_W     = 6
) (
  input  logic             req_write,
  input  logic [VPN_W-1:0] vpn,
  input  logic             perm_rd,
  input  logic             perm_wr,
  output pxu_cause_e       cause,
  output logic             acc_ok
);

  logic in_range;
  assign in_range = int'(vpn) < NUM_PAGES;
  assign cause    = pxu_classify(in_range, perm_rd, perm_wr, req_write);
  assign acc_ok   = (cause == CAUSE_NONE);

endmodule

// File: rtl/pxu_resp_reg.sv
module pxu_resp_reg
  import pxu_pkg::*;
#(
  parameter int VPN_W = 6,
  parameter int PA_W  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  pxu_cause_e       acc_cause,
  input  logic [VPN_W-1:0] acc_vpn,
  input  logic [PA_W-1:0]  acc_paddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [VPN_W-1:0] rsp_fault_vpn,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic acc_fault;
  assign acc_fault = (acc_cause != CAUSE_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_cause     <= 2'd0;
      rsp_fault_vpn <= '0;
      rsp_paddr     <= '0;
    end else begin
      rsp_valid <= acc_valid;
      if (acc_valid) begin
        rsp_fault     <= acc_fault;
        rsp_cause     <= acc_cause;
        rsp_fault_vpn <= acc_fault ? acc_vpn : '0;
        rsp_paddr     <= acc_fault ? '0 : acc_paddr;
      end
    end
  end

  // R1: exactly one cycle of latency.
  assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  // R6: a faulting response reports the requested page number and no address.
  assert_fault_vpn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_fault_vpn == $past(acc_vpn)) && (rsp_paddr == '0));

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int OFF_W     = 10,
  parameter int PFN_W     = 8,
  parameter int NUM_PAGES = 48,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PA_W     = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [VPN_W-1:0] rsp_fault_vpn,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             sw_wr_en,
  input  logic [VPN_W-1:0] sw_idx,
  input  logic [PFN_W-1:0] sw_pfn,
  input  logic             sw_perm_rd,
  input  logic             sw_perm_wr,
  input  logic             sw_ref,
  input  logic             sw_dirty,
  output logic [PFN_W-1:0] rb_pfn,
  output logic             rb_perm_rd,
  output logic             rb_perm_wr,
  output logic             rb_ref,
  output logic             rb_dirty
);

  initial begin
    if (NUM_PAGES > (1 << VPN_W) || NUM_PAGES < 1)
      $error("NUM_PAGES must fit the page number field");
  end

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [VA_W-1:0]  va);
    return {pfn, va[OFF_W-1:0]};
  endfunction

  logic [VPN_W-1:0] req_vpn;
  logic [PFN_W-1:0] lk_pfn;
  logic             lk_perm_rd;
  logic             lk_perm_wr;
  pxu_cause_e       acc_cause;
  logic             acc_ok;
  logic             hit_ok;
  logic             hit_store;
  logic [PA_W-1:0]  acc_paddr;

  assign req_vpn   = page_of(req_vaddr);
  assign hit_ok    = req_valid && acc_ok;
  assign hit_store = hit_ok && req_write;
  assign acc_paddr = join_pa(lk_pfn, req_vaddr);

  pxu_entry_store #(
    .NUM_PAGES (NUM_PAGES),
    .VPN_W     (VPN_W),
    .PFN_W     (PFN_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_wr_en     (sw_wr_en),
    .sw_idx       (sw_idx),
    .sw_pfn       (sw_pfn),
    .sw_perm_rd   (sw_perm_rd),
    .sw_perm_wr   (sw_perm_wr),
    .sw_ref       (sw_ref),
    .sw_dirty     (sw_dirty),
    .lk_vpn       (req_vpn),
    .lk_pfn       (lk_pfn),
    .lk_perm_rd   (lk_perm_rd),
    .lk_perm_wr   (lk_perm_wr),
    .upd_ref_en   (hit_ok),
    .upd_dirty_en (hit_store),
    .upd_vpn      (req_vpn),
    .rb_pfn       (rb_pfn),
    .rb_perm_rd   (rb_perm_rd),
    .rb_perm_wr   (rb_perm_wr),
    .rb_ref       (rb_ref),
    .rb_dirty     (rb_dirty)
  );

  pxu_access_check #(
    .NUM_PAGES (NUM_PAGES),
    .VPN_W     (VPN_W)
  ) u_check (
    .req_write (req_write),
    .vpn       (req_vpn),
    .perm_rd   (lk_perm_rd),
    .perm_wr   (lk_perm_wr),
    .cause     (acc_cause),
    .acc_ok    (acc_ok)
  );

  pxu_resp_reg #(
    .VPN_W (VPN_W),
    .PA_W  (PA_W)
  ) u_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (req_valid),
    .acc_cause     (acc_cause),
    .acc_vpn       (req_vpn),
    .acc_paddr     (acc_paddr),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .rsp_fault_vpn (rsp_fault_vpn),
    .rsp_paddr     (rsp_paddr)
  );

  // R2: the page offset passes through unchanged on success.
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  // R3: out-of-range pages never translate.
  assert_range_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_vpn) >= NUM_PAGES) |=> (rsp_fault && rsp_cause == 2'd1));

endmodule

// File: tb/page_xlate_unit_tb.sv
`timescale 1ns/1ps
module page_xlate_unit_tb;

  localparam int VA_W  = 16;
  localparam int OFF_W = 10;
  localparam int PFN_W = 8;
  localparam int NPG   = 48;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic             rsp_valid, rsp_fault;
  logic [1:0]       rsp_cause;
  logic [VPN_W-1:0] rsp_fault_vpn;
  logic [PA_W-1:0]  rsp_paddr;
  logic             sw_wr_en = 1'b0;
  logic [VPN_W-1:0] sw_idx = '0;
  logic [PFN_W-1:0] sw_pfn = '0;
  logic             sw_perm_rd = 1'b0, sw_perm_wr = 1'b0, sw_ref = 1'b0, sw_dirty = 1'b0;
  logic [PFN_W-1:0] rb_pfn;
  logic             rb_perm_rd, rb_perm_wr, rb_ref, rb_dirty;

  always #2.5 clk = ~clk;

  page_xlate_unit #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .NUM_PAGES(NPG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_fault_vpn(rsp_fault_vpn), .rsp_paddr(rsp_paddr),
    .sw_wr_en(sw_wr_en), .sw_idx(sw_idx), .sw_pfn(sw_pfn), .sw_perm_rd(sw_perm_rd),
    .sw_perm_wr(sw_perm_wr), .sw_ref(sw_ref), .sw_dirty(sw_dirty), .rb_pfn(rb_pfn),
    .rb_perm_rd(rb_perm_rd), .rb_perm_wr(rb_perm_wr), .rb_ref(rb_ref), .rb_dirty(rb_dirty));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // Bench model of the table.
  logic [PFN_W-1:0] m_pfn [64];
  logic m_rd [64], m_wr [64], m_ref [64], m_dirty [64];

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input int idx, input int pfn, input logic rd, input logic wr,
                          input logic rf, input logic dt);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_idx = VPN_W'(idx); sw_pfn = PFN_W'(pfn);
    sw_perm_rd = rd; sw_perm_wr = wr; sw_ref = rf; sw_dirty = dt;
    @(negedge clk);
    sw_wr_en = 1'b0;
    if (idx < NPG) begin
      m_pfn[idx] = PFN_W'(pfn); m_rd[idx] = rd; m_wr[idx] = wr;
      m_ref[idx] = rf; m_dirty[idx] = dt;
    end
  endtask

  // Readback of one entry's tracking flags compared with the model.
  task automatic check_flags(input int idx, input string tag);
    sw_idx = VPN_W'(idx);
    #0.5;
    check(rb_ref == m_ref[idx], {tag, " accessed flag"}, rb_ref, m_ref[idx]);
    check(rb_dirty == m_dirty[idx], {tag, " modified flag"}, rb_dirty, m_dirty[idx]);
  endtask

  // Vector: {store, page, offset, expected cause}
  localparam int VW = 1 + VPN_W + OFF_W + 2;
  localparam logic [VW-1:0] VECS [12] = '{
    {1'b0, 6'd1,  10'h005, 2'd0},
    {1'b1, 6'd1,  10'h3ff, 2'd0},
    {1'b0, 6'd2,  10'h100, 2'd0},
    {1'b1, 6'd2,  10'h001, 2'd3},
    {1'b0, 6'd3,  10'h010, 2'd3},
    {1'b1, 6'd3,  10'h222, 2'd0},
    {1'b0, 6'd0,  10'h000, 2'd2},
    {1'b1, 6'd0,  10'h0aa, 2'd2},
    {1'b0, 6'd47, 10'h3ff, 2'd0},
    {1'b0, 6'd48, 10'h000, 2'd1},
    {1'b1, 6'd63, 10'h155, 2'd1},
    {1'b0, 6'd5,  10'h044, 2'd2}
  };

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_pfn[i] = '0; m_rd[i] = 0; m_wr[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
    end
    repeat (3) @(negedge clk);
    // Reset state (R1, R10)
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
    sw_idx = 6'd1; #0.5;
    check({rb_pfn, rb_perm_rd, rb_perm_wr, rb_ref, rb_dirty} == '0, "R10 reset entry",
          {rb_pfn, rb_perm_rd, rb_perm_wr, rb_ref, rb_dirty}, 0);
    rst_n = 1'b1;

    sw_write(1, 8'h21, 1, 1, 0, 0);
    sw_write(2, 8'h42, 1, 0, 0, 0);
    sw_write(3, 8'h7f, 0, 1, 0, 0);
    sw_write(47, 8'hff, 1, 1, 0, 0);
    sw_idx = 6'd2; #0.5;
    check(rb_pfn == 8'h42 && rb_perm_rd && !rb_perm_wr, "R10 readback fields", rb_pfn, 8'h42);

    foreach (VECS[k]) begin
      logic             st;
      logic [VPN_W-1:0] pg;
      logic [OFF_W-1:0] off;
      logic [1:0]       ec;
      string            t;
      {st, pg, off, ec} = VECS[k];
      t = tag_of(ec);
      @(negedge clk);
      req_valid = 1'b1; req_write = st; req_vaddr = {pg, off};
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R1 response strobe", rsp_valid, 1);
      check(rsp_cause == ec, {t, " cause"}, rsp_cause, ec);
      check(rsp_fault == (ec != 0), "R6 fault flag", rsp_fault, ec != 0);
      if (ec == 0) begin
        check(rsp_paddr == {m_pfn[pg], off}, "R2 physical address", rsp_paddr, {m_pfn[pg], off});
        m_ref[pg] = 1'b1;
        if (st) m_dirty[pg] = 1'b1;
      end else begin
        check(rsp_fault_vpn == pg && rsp_paddr == '0, "R6 fault page", rsp_fault_vpn, pg);
      end
      if (int'(pg) < NPG)
        check_flags(pg, ec == 0 ? (st ? "R8" : "R7") : "R9");
    end

    // Idle cycle: no response (R1)
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 idle", rsp_valid, 0);

    // Software clears flags, then a load sets only the accessed flag (R10, R8)
    sw_write(1, 8'h21, 1, 1, 0, 0);
    check_flags(1, "R10 clear");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = {6'd1, 10'h0c3};
    @(negedge clk);
    req_valid = 1'b0;
    m_ref[1] = 1'b1;
    check_flags(1, "R8 load keeps modified");

    // Collision: software write and store to page 1 on the same edge (R11)
    @(negedge clk);
    sw_wr_en = 1'b1; sw_idx = 6'd1; sw_pfn = 8'h99; sw_perm_rd = 1'b1; sw_perm_wr = 1'b1;
    sw_ref = 1'b0; sw_dirty = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = {6'd1, 10'h012};
    @(negedge clk);
    sw_wr_en = 1'b0; req_valid = 1'b0;
    check(!rsp_fault && rsp_paddr == {8'h21, 10'h012}, "R11 old contents used",
          rsp_paddr, {8'h21, 10'h012});
    m_pfn[1] = 8'h99; m_ref[1] = 1'b0; m_dirty[1] = 1'b0;
    check_flags(1, "R11 software wins");

    // Out-of-range software write ignored, readback zero (R10)
    sw_write(50, 8'h55, 1, 1, 1, 1);
    sw_idx = 6'd50; #0.5;
    check({rb_pfn, rb_perm_rd, rb_ref} == '0, "R10 out-of-range index", rb_pfn, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = {6'd50, 10'h001};
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_cause == 2'd1, "R3 page 50 after ignored write", rsp_cause, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule